// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a bus-programmed watchdog. A 32-bit down-counter runs while enabled. Software keeps it from expiring by writing a fixed key word to a kick register, which reloads the counter from a programmable reload value. The counter steps either on every system clock or on a 1 MHz tick. That tick is made inside the block by dividing the system clock by a parameter.

When the counter takes a step while it already sits at zero, the block expires. It emits a one-cycle timeout pulse, reloads the counter and sets a sticky timeout flag. Depending on control bits, it also raises a reset request tagged with a reset mode, raises an external-reset request for a separate pulse-shaping block, and latches a "boot from alternate image" flag.

An early-warning threshold, held in the upper control bits, raises a level interrupt before expiry. One clear command drops the timeout flag, the alternate-boot flag and the interrupt together. Two mask words are kept as plain storage for a neighbouring reset-distribution block.

Top module: `wdog_top`

## Requirements
- R1: After reset the count (0x00) and reload (0x04) registers read RST_RELOAD (default 0x00FF_FFFF), while control (0x0C) and status (0x10) read zero; irq, tmo_pulse, rst_req and ext_rst_req are low.
- R2: The reload register at 0x04 is read/write. The control register at 0x0C is read/write with bits 9:8 always reading zero. The count at 0x00 is read-only. The kick (0x08) and clear (0x14) registers read zero.
- R3: A write of exactly 0x0000_4755 to 0x08 loads the count from the reload register whether or not the counter is enabled. Any other value written there leaves the count unchanged. A kick in the same cycle as an expiry step wins, and no timeout occurs.
- R4: While control bit 0 (enable) is clear the count holds. A control write never reloads the count.
- R5: With enable set and control bit 4 clear, the count decrements by one on every clock.
- R6: A counting step taken while the count is zero produces a one-cycle tmo_pulse, reloads the count and sets status bit 0 (sticky).
- R7: If control bit 1 is set at expiry, rst_req pulses with tmo_pulse and rst_mode takes control bits 6:5 (0 SoC, 1 full chip, 2 CPU only). Otherwise rst_req stays low.
- R8: If control bit 3 is set at expiry, ext_rst_req pulses with tmo_pulse.
- R9: If control bit 7 is set at expiry, status bit 1 (alternate boot) sets and stays set.
- R10: Writing 0x14 with bit 0 set clears status bits 2:0 together. A write with bit 0 clear has no effect. A set condition in the same cycle wins over the clear.
- R11: With enable and control bit 2 set, a count equal to {ctrl[31:10], 10'b0} sets status bit 2. The irq output is high exactly while that bit is set.
- R12: With control bit 4 set, the counter steps only on a tick that occurs once every DIV clocks.
- R13: Registers 0x1C and 0x20 store and return any 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Early-warning interrupt, level high |
| tmo_pulse | output | 1 | One-cycle expiry event |
| rst_req | output | 1 | One-cycle reset request at expiry |
| rst_mode | output | 2 | Reset mode latched with the last reset request |
| ext_rst_req | output | 1 | One-cycle request to the external pulse shaper |

## Verification
The bench aims at the exact step count to expiry. A design that fired on the 1-to-0 step, or reloaded late, would show the wrong count or a missing pulse in the sampled cycle. Near-miss kick values and control writes with enable clear are both checked against an unchanged count, so a loose key compare or a reload on control write shows up at once. The early-warning interrupt is sampled one cycle before and one cycle after the threshold match. The clear register is also written with bit 0 low, so an off-by-one threshold or a clear that ignores its data bit fails a check. The tick mode is checked to be much slower than clock mode, which catches a swapped step select.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int AW = 6;
    localparam int DW = 32;

    localparam logic [AW-1:0] OFF_COUNT  = 6'h00;
    localparam logic [AW-1:0] OFF_RELOAD = 6'h04;
    localparam logic [AW-1:0] OFF_KICK   = 6'h08;
    localparam logic [AW-1:0] OFF_CTRL   = 6'h0C;
    localparam logic [AW-1:0] OFF_STAT   = 6'h10;
    localparam logic [AW-1:0] OFF_CLR    = 6'h14;
    localparam logic [AW-1:0] OFF_MASK0  = 6'h1C;
    localparam logic [AW-1:0] OFF_MASK1  = 6'h20;

    localparam logic [DW-1:0] KICK_WORD  = 32'h0000_4755;
    localparam logic [DW-1:0] CTRL_WMASK = 32'hFFFF_FCFF;

    localparam int CB_EN     = 0;
    localparam int CB_SYSRST = 1;
    localparam int CB_IE     = 2;
    localparam int CB_EXT    = 3;
    localparam int CB_TICK   = 4;
    localparam int CB_MODE   = 5;
    localparam int CB_BOOT2  = 7;
    localparam int THR_LSB   = 10;

    typedef enum logic [1:0] {
        MODE_SOC  = 2'd0,
        MODE_FULL = 2'd1,
        MODE_CPU  = 2'd2,
        MODE_RSVD = 2'd3
    } rst_mode_e;

    typedef struct packed {
        logic [DW-1:0] reload;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] mask0;
        logic [DW-1:0] mask1;
    } regs_t;

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          tmo;
        logic          boot2;
        logic          irq;
        logic          evt;
        logic          rst;
        logic          ext;
        rst_mode_e     mode;
    } cnt_t;
endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_d, div_q;

    always_comb begin
        tick  = (div_q == LAST);
        div_d = tick ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter logic [31:0] RST_RELOAD = 32'h00FF_FFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cnt,
    input  logic [2:0]    stat,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] ctrl,
    output logic [DW-1:0] reload,
    output logic          kick,
    output logic          clr
);
    regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        kick = we && (addr == OFF_KICK) && (wdata == KICK_WORD);
        clr  = we && (addr == OFF_CLR) && wdata[0];
        if (we) begin
            case (addr)
                OFF_RELOAD: r_d.reload = wdata;
                OFF_CTRL:   r_d.ctrl   = wdata & CTRL_WMASK;
                OFF_MASK0:  r_d.mask0  = wdata;
                OFF_MASK1:  r_d.mask1  = wdata;
                default: ;
            endcase
        end
        case (addr)
            OFF_COUNT:  rdata = cnt;
            OFF_RELOAD: rdata = r_q.reload;
            OFF_CTRL:   rdata = r_q.ctrl;
            OFF_STAT:   rdata = {29'd0, stat};
            OFF_MASK0:  rdata = r_q.mask0;
            OFF_MASK1:  rdata = r_q.mask1;
            default:    rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{reload: RST_RELOAD, ctrl: '0, mask0: '0, mask1: '0};
        else        r_q <= r_d;
    end

    assign ctrl   = r_q.ctrl;
    assign reload = r_q.reload;
endmodule

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter logic [31:0] RST_RELOAD = 32'h00FF_FFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ctrl,
    input  logic [DW-1:0] reload,
    input  logic          tick,
    input  logic          kick,
    input  logic          clr,
    output logic [DW-1:0] cnt,
    output logic [2:0]    stat,
    output logic          evt,
    output logic          rst,
    output logic          ext,
    output logic [1:0]    mode
);
    cnt_t s_d, s_q;
    logic step, fire, at_thr;
    logic unused_ctrl;

    assign unused_ctrl = ^ctrl[THR_LSB-1:CB_BOOT2+1];

    always_comb begin
        s_d     = s_q;
        s_d.evt = 1'b0;
        s_d.rst = 1'b0;
        s_d.ext = 1'b0;
        step    = ctrl[CB_EN] & (ctrl[CB_TICK] ? tick : 1'b1);
        fire    = step & (s_q.cnt == '0) & ~kick;
        at_thr  = (s_q.cnt == {ctrl[DW-1:THR_LSB], {THR_LSB{1'b0}}});

        if (kick || fire) s_d.cnt = reload;
        else if (step)    s_d.cnt = s_q.cnt - 1'b1;

        if (clr) begin
            s_d.tmo   = 1'b0;
            s_d.boot2 = 1'b0;
            s_d.irq   = 1'b0;
        end
        if (fire) begin
            s_d.evt = 1'b1;
            s_d.tmo = 1'b1;
            s_d.rst = ctrl[CB_SYSRST];
            s_d.ext = ctrl[CB_EXT];
            if (ctrl[CB_SYSRST]) s_d.mode = rst_mode_e'(ctrl[CB_MODE+1:CB_MODE]);
            if (ctrl[CB_BOOT2])  s_d.boot2 = 1'b1;
        end
        if (ctrl[CB_EN] && ctrl[CB_IE] && at_thr) s_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.cnt  <= RST_RELOAD;
            s_q.mode <= MODE_SOC;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt  = s_q.cnt;
    assign stat = {s_q.irq, s_q.boot2, s_q.tmo};
    assign evt  = s_q.evt;
    assign rst  = s_q.rst;
    assign ext  = s_q.ext;
    assign mode = s_q.mode;
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int          DIV        = 50,
    parameter logic [31:0] RST_RELOAD = 32'h00FF_FFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [5:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        tmo_pulse,
    output logic        rst_req,
    output logic [1:0]  rst_mode,
    output logic        ext_rst_req
);
    logic [DW-1:0] ctrl_w, reload_w, cnt_w;
    logic [2:0]    stat_w;
    logic          kick_w, clr_w, tick_w;

    wdog_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_w)
    );

    wdog_regs #(.RST_RELOAD(RST_RELOAD)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .cnt   (cnt_w),
        .stat  (stat_w),
        .rdata (bus_rdata),
        .ctrl  (ctrl_w),
        .reload(reload_w),
        .kick  (kick_w),
        .clr   (clr_w)
    );

    wdog_count #(.RST_RELOAD(RST_RELOAD)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .ctrl  (ctrl_w),
        .reload(reload_w),
        .tick  (tick_w),
        .kick  (kick_w),
        .clr   (clr_w),
        .cnt   (cnt_w),
        .stat  (stat_w),
        .evt   (tmo_pulse),
        .rst   (rst_req),
        .ext   (ext_rst_req),
        .mode  (rst_mode)
    );

    assign irq = stat_w[2];
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ctrl,
    input logic [31:0] reload,
    input logic [31:0] cnt,
    input logic        kick,
    input logic        clr,
    input logic        tmo_pulse,
    input logic        rst_req,
    input logic        ext_rst_req,
    input logic [2:0]  stat
);
    AST_KICK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == $past(reload)));                                   // R3
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[0] && !kick) |=> $stable(cnt));                               // R4
    AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |-> ($past(cnt) == 32'd0 && $past(ctrl[0]) && !$past(kick))); // R6
    AST_RST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (tmo_pulse && $past(ctrl[1])));                          // R7
    AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rst_req |-> (tmo_pulse && $past(ctrl[3])));                      // R8
    AST_BOOT2_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[1]) |-> (tmo_pulse && $past(ctrl[7])));                   // R9
    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat[0]) |-> $past(clr));                                      // R10
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[2]) |-> ($past(ctrl[2]) && $past(ctrl[0])));              // R11
endmodule

bind wdog_top wdog_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl       (ctrl_w),
    .reload     (reload_w),
    .cnt        (cnt_w),
    .kick       (kick_w),
    .clr        (clr_w),
    .tmo_pulse  (tmo_pulse),
    .rst_req    (rst_req),
    .ext_rst_req(ext_rst_req),
    .stat       (stat_w)
);

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
    localparam logic [5:0] A_CNT = 6'h00, A_RLD = 6'h04, A_KICK = 6'h08, A_CTL = 6'h0C;
    localparam logic [5:0] A_STS = 6'h10, A_CLR = 6'h14, A_M0 = 6'h1C, A_M1 = 6'h20;
    localparam logic [31:0] KEY = 32'h0000_4755;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, tmo_pulse, rst_req, ext_rst_req;
    logic [1:0]  rst_mode;

    int n_chk = 0, n_err = 0;
    int n_evt = 0, n_rst = 0, n_ext = 0;
    logic [1:0] last_mode = '0;

    always #10 clk = ~clk;

    wdog_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .tmo_pulse(tmo_pulse), .rst_req(rst_req), .rst_mode(rst_mode),
        .ext_rst_req(ext_rst_req)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (tmo_pulse) n_evt++;
            if (rst_req) begin n_rst++; last_mode = rst_mode; end
            if (ext_rst_req) n_ext++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic arm(input logic [31:0] rl, input logic [31:0] c);
        wr(A_CTL, 32'h0);
        wr(A_CLR, 32'h1);
        wr(A_RLD, rl);
        wr(A_KICK, KEY);
        wr(A_CTL, c);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(A_CNT, d); check("R1 count", d, 32'h00FF_FFFF);
        rd(A_RLD, d); check("R1 reload", d, 32'h00FF_FFFF);
        rd(A_CTL, d); check("R1 ctrl", d, 32'h0);
        rd(A_STS, d); check("R1 status", d, 32'h0);
        check("R1 outputs", {28'd0, irq, tmo_pulse, rst_req, ext_rst_req}, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] d;
        wr(A_CTL, 32'hFFFF_FF7E);
        rd(A_CTL, d); check("R2 ctrl bits 9:8 zero", d, 32'hFFFF_FC7E);
        wr(A_CTL, 32'h0);
        wr(A_RLD, 32'h0000_000A);
        rd(A_RLD, d); check("R2 reload rw", d, 32'h0000_000A);
        wr(A_CNT, 32'h1234_5678);
        rd(A_CNT, d); check("R2 count read-only", d, 32'h00FF_FFFF);
        rd(A_KICK, d); check("R2 kick reads zero", d, 32'h0);
    endtask

    task automatic t_kick;
        logic [31:0] d;
        wr(A_KICK, 32'h0000_1234);
        rd(A_CNT, d); check("R3 wrong key ignored", d, 32'h00FF_FFFF);
        wr(A_KICK, 32'h0001_4755);
        rd(A_CNT, d); check("R3 upper bits must be zero", d, 32'h00FF_FFFF);
        wr(A_KICK, KEY);
        rd(A_CNT, d); check("R3 key loads count", d, 32'h0000_000A);
    endtask

    task automatic t_hold;
        logic [31:0] d;
        cyc(5);
        rd(A_CNT, d); check("R4 holds while disabled", d, 32'd10);
        wr(A_RLD, 32'd20);
        wr(A_CTL, 32'h0000_0002);
        rd(A_CNT, d); check("R4 ctrl write does not reload", d, 32'd10);
    endtask

    task automatic t_countdown;
        logic [31:0] d;
        arm(32'd10, 32'h0000_0001);
        cyc(4);
        rd(A_CNT, d); check("R5 one per clock", d, 32'd6);
    endtask

    task automatic t_expire;
        logic [31:0] d;
        int e0, r0;
        e0 = n_evt; r0 = n_rst;
        arm(32'd5, 32'h0000_0043); // enable, sysrst, mode 2 (CPU)
        cyc(5);
        #1;
        check("R6 no pulse before zero step", n_evt - e0, 0);
        cyc(1);
        #1;
        check("R6 one pulse", n_evt - e0, 1);
        rd(A_CNT, d); check("R6 reload after expiry", d, 32'd5);
        rd(A_STS, d); check("R6 sticky flag", d, 32'h1);
        check("R7 reset request", n_rst - r0, 1);
        check("R7 mode CPU", {30'd0, last_mode}, 32'd2);
        cyc(1);
        rd(A_STS, d); check("R6 flag stays", d, 32'h1);
    endtask

    task automatic t_boot2;
        logic [31:0] d;
        int r0, x0, e0;
        r0 = n_rst; x0 = n_ext; e0 = n_evt;
        arm(32'd3, 32'h0000_0089); // enable, ext, boot2, no sysrst
        cyc(4);
        #1;
        check("R6 pulse", n_evt - e0, 1);
        check("R7 no reset without bit1", n_rst - r0, 0);
        check("R8 ext request", n_ext - x0, 1);
        rd(A_STS, d); check("R9 alt boot flag", d, 32'h3);
        wr(A_CTL, 32'h0);
        wr(A_CLR, 32'h0);
        rd(A_STS, d); check("R10 clear bit0 low ignored", d, 32'h3);
        wr(A_CLR, 32'h1);
        rd(A_STS, d); check("R10 clear all", d, 32'h0);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        arm(32'd1030, 32'h0000_0405); // threshold 1 -> 1024, ie, enable
        cyc(6);
        check("R11 irq low before match", {31'd0, irq}, 32'd0);
        cyc(1);
        check("R11 irq high after match", {31'd0, irq}, 32'd1);
        rd(A_STS, d); check("R11 status bit2", d, 32'h4);
        wr(A_CTL, 32'h0);
        wr(A_CLR, 32'h1);
        check("R10 clear drops irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_live_kick;
        int e0;
        e0 = n_evt;
        arm(32'd10, 32'h0000_0001);
        for (int i = 0; i < 8; i++) begin
            cyc(4);
            wr(A_KICK, KEY);
        end
        #1;
        check("R3 regular kicks prevent expiry", n_evt - e0, 0);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_tick;
        logic [31:0] d;
        int e0;
        arm(32'd2, 32'h0000_0011);
        e0 = n_evt;
        cyc(30);
        rd(A_CNT, d); check("R12 slow step", (d >= 32'd1) ? 32'd1 : 32'd0, 32'd1);
        cyc(300);
        #1;
        check("R12 expires on ticks", ((n_evt - e0) >= 1 && (n_evt - e0) <= 3) ? 1 : 0, 1);
        wr(A_CTL, 32'h0);
    endtask

    task automatic t_masks;
        logic [31:0] d;
        wr(A_M0, 32'hA5A5_0F0F);
        wr(A_M1, 32'h1357_9BDF);
        rd(A_M0, d); check("R13 mask0", d, 32'hA5A5_0F0F);
        rd(A_M1, d); check("R13 mask1", d, 32'h1357_9BDF);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_map();
        t_kick();
        t_hold();
        t_countdown();
        t_expire();
        t_boot2();
        t_irq();
        t_live_kick();
        t_tick();
        t_masks();
        summary();
        $finish;
    end
endmodule